// File: doc/BRIEF.md
# Serial-Loaded Converter Code Register

This block is the digital front end of a 14-bit serial-input digital-to-analog converter. A host sends each new code as a 16-bit serial frame on three wires: an active-low select, a serial clock and a data line. Every serial input is brought into the system clock domain through a two-flop synchronizer, and edges are found by comparing successive samples. Each sampled bit enters an input shift register. When the select line goes high, a frame of exactly sixteen bits moves its 14 code bits into a holding latch. That latch drives the converter code output.

A parameter picks the unipolar or the bipolar variant. The variant sets the clear code, which the latch takes at reset and whenever the asynchronous active-low clear input is low. In the bipolar variant the code is offset binary: midscale 0x2000 is the zero point, 0x3FFF is the most positive value and 0x0000 is the most negative. Each completed transfer gives a one-cycle update strobe. A sticky flag reports frames whose two trailing sub-bits were not zero. The system clock must run at least four times faster than the serial clock.

Top module: `dac_serial_loader`

## Requirements
- R1: At reset the code output equals the clear code. The clear code is 0 when BIPOLAR=0 and 0x2000 (8192) when BIPOLAR=1. The strobe and the sub-bit flag reset to 0.
- R2: A frame starts when the select line falls. While select is low, each rising serial-clock edge samples one data bit. Bit 1 of the frame is the code MSB and bit 14 is the code LSB. Bits 15 and 16 are sub-bits.
- R3: The code output does not change during a frame. It takes the new code only after the select line rises.
- R4: A frame with fewer than 16 serial-clock edges is discarded, and the code output keeps its value.
- R5: A frame with more than 16 serial-clock edges is discarded, and the code output keeps its value.
- R6: A 16-bit frame with nonzero sub-bits still loads its code and sets the sub-bit flag. The flag holds through discarded frames. The next 16-bit frame with both sub-bits zero clears it.
- R7: While the clear input is low, the code output equals the clear code at once, without any clock edge.
- R8: Each loaded frame raises the update strobe for exactly one system cycle. A discarded frame or a clear event raises no strobe.
- R9: A clear pulse during a frame does not disturb the shifting. If that frame completes after the clear is released, it loads normally.
- R10: Serial-clock edges while the select line is high shift nothing and change nothing at the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel_n | input | 1 | Active-low frame select (asynchronous) |
| sclk | input | 1 | Serial clock (asynchronous) |
| sdata | input | 1 | Serial data, MSB first (asynchronous) |
| clr_n | input | 1 | Asynchronous active-low clear to the clear code |
| code_o | output | CODE_W | Latched converter code |
| upd_o | output | 1 | One-cycle strobe per loaded frame |
| subbit_err_o | output | 1 | Sticky flag for nonzero sub-bits |

## Verification
The bench checks the bit-count boundary with frames of 15, 16 and 17 bits. A counter that is off by one would load a short or long frame, or reject the proper one. It checks that the output holds after the sixteenth bit until select rises, which catches a design that loads on the bit count. It pulses the clear in the middle of a frame and expects that frame to load once the clear is released, which catches a design that wipes the shift register on clear. It follows the sub-bit flag through a discarded frame, and it counts strobes to catch double pulses and strobes raised by discarded frames or by a clear.

// File: rtl/dfl_pkg.sv
package dfl_pkg;
  // Clear code for the selected variant: zero for unipolar, midscale for bipolar.
  function automatic logic [31:0] clear_code(input bit bipolar, input int code_w);
    logic [31:0] v;
    v = 32'd0;
    if (bipolar) v[code_w-1] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/dfl_reset_sync.sv
module dfl_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/dfl_in_sync.sv
module dfl_in_sync #(
  parameter int          WIDTH  = 3,
  parameter int          STAGES = 2,
  parameter logic [WIDTH-1:0] IDLE = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] ff_q;
    logic [STAGES-1:0] ff_d;
    always_comb ff_d = {ff_q[STAGES-2:0], async_i[b]};
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff_q <= {STAGES{IDLE[b]}};
      else        ff_q <= ff_d;
    end
    assign sync_o[b] = ff_q[STAGES-1];
  end
endmodule

// File: rtl/dfl_frame_rx.sv
module dfl_frame_rx #(
  parameter int FRAME_W = 16,
  parameter int CNT_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_n_s,
  input  logic               sclk_s,
  input  logic               sdata_s,
  output logic [FRAME_W-1:0] frame_o,
  output logic [CNT_W-1:0]   bit_cnt_o,
  output logic               xfer_o
);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  logic               sel_prev_q, sclk_prev_q;
  logic [FRAME_W-1:0] sreg_q, sreg_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               sel_fall, sel_rise, sclk_rise, shift_en;

  always_comb begin
    sel_fall  = sel_prev_q & ~sel_n_s;
    sel_rise  = ~sel_prev_q & sel_n_s;
    sclk_rise = sclk_s & ~sclk_prev_q;
    shift_en  = sclk_rise & ~sel_n_s & ~sel_fall;
  end

  always_comb begin
    sreg_d = sreg_q;
    cnt_d  = cnt_q;
    if (sel_fall) begin
      cnt_d = '0;
    end else if (shift_en) begin
      sreg_d = {sreg_q[FRAME_W-2:0], sdata_s};
      if (cnt_q != CNT_SAT) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_prev_q  <= 1'b1;
      sclk_prev_q <= 1'b0;
      sreg_q      <= '0;
      cnt_q       <= CNT_SAT;
    end else begin
      sel_prev_q  <= sel_n_s;
      sclk_prev_q <= sclk_s;
      if (shift_en) sreg_q <= sreg_d;
      if (sel_fall || shift_en) cnt_q <= cnt_d;
    end
  end

  assign frame_o   = sreg_q;
  assign bit_cnt_o = cnt_q;
  assign xfer_o    = sel_rise && (cnt_q == CNT_FULL);
endmodule

// File: rtl/dfl_code_latch.sv
module dfl_code_latch #(
  parameter int CODE_W = 14,
  parameter int SUB_W  = 2,
  parameter logic [CODE_W-1:0] CLEAR = '0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr_n,
  input  logic                    xfer,
  input  logic [CODE_W+SUB_W-1:0] frame,
  output logic [CODE_W-1:0]       code_o,
  output logic                    upd_o,
  output logic                    err_o
);
  logic              latch_arst_n;
  logic [CODE_W-1:0] code_q, code_d;
  logic              upd_q, upd_d;
  logic              err_q, err_d;

  assign latch_arst_n = rst_n & clr_n;

  always_comb begin
    code_d = frame[CODE_W+SUB_W-1 -: CODE_W];
    upd_d  = xfer;
    err_d  = |frame[SUB_W-1:0];
  end

  always_ff @(posedge clk or negedge latch_arst_n) begin
    if (!latch_arst_n) begin
      code_q <= CLEAR;
      upd_q  <= 1'b0;
    end else begin
      if (xfer) code_q <= code_d;
      upd_q <= upd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    err_q <= 1'b0;
    else if (xfer) err_q <= err_d;
  end

  assign code_o = code_q;
  assign upd_o  = upd_q;
  assign err_o  = err_q;
endmodule

// File: rtl/dac_serial_loader.sv
module dac_serial_loader #(
  parameter int CODE_W      = 14,
  parameter int SUB_W       = 2,
  parameter bit BIPOLAR     = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              sclk,
  input  logic              sdata,
  input  logic              clr_n,
  output logic [CODE_W-1:0] code_o,
  output logic              upd_o,
  output logic              subbit_err_o
);
  localparam int FRAME_W = CODE_W + SUB_W;
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam logic [CODE_W-1:0] CLEAR = CODE_W'(dfl_pkg::clear_code(BIPOLAR, CODE_W));

  logic               rst_sync_n;
  logic [2:0]         pins_s;
  logic [FRAME_W-1:0] frame_word;
  logic [CNT_W-1:0]   bit_cnt;
  logic               xfer;

  dfl_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  // Bit order: [2] select (idle high), [1] serial clock, [0] data.
  dfl_in_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .IDLE(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_sync_n),
    .async_i({sel_n, sclk, sdata}), .sync_o(pins_s)
  );

  dfl_frame_rx #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_sync_n),
    .sel_n_s(pins_s[2]), .sclk_s(pins_s[1]), .sdata_s(pins_s[0]),
    .frame_o(frame_word), .bit_cnt_o(bit_cnt), .xfer_o(xfer)
  );

  dfl_code_latch #(.CODE_W(CODE_W), .SUB_W(SUB_W), .CLEAR(CLEAR)) u_latch (
    .clk(clk), .rst_n(rst_sync_n), .clr_n(clr_n),
    .xfer(xfer), .frame(frame_word),
    .code_o(code_o), .upd_o(upd_o), .err_o(subbit_err_o)
  );
endmodule

// File: rtl/dfl_checker.sv
module dfl_checker #(
  parameter int CODE_W  = 14,
  parameter int SUB_W   = 2,
  parameter int CNT_W   = 5,
  parameter logic [CODE_W-1:0] CLEAR = '0
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    clr_n,
  input logic [CODE_W-1:0]       code,
  input logic                    upd,
  input logic                    err,
  input logic [CNT_W-1:0]        bit_cnt,
  input logic [CODE_W+SUB_W-1:0] frame_word
);
  // R7: clear forces the clear code
  p_clear_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> code == CLEAR);

  // R8: strobe lasts one cycle and never appears during clear
  p_single_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> !upd);
  p_no_strobe_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> !upd);

  // R4/R5: a load only follows a frame of exactly FRAME_W bits
  p_exact_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    upd |-> $past(bit_cnt) == CNT_W'(CODE_W + SUB_W));

  // R2: the loaded code is the first CODE_W bits of the frame
  p_code_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
    upd |-> code == $past(frame_word[CODE_W+SUB_W-1 -: CODE_W]));

  // R3: without a strobe or clear the code holds
  p_code_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && $past(clr_n) && !upd) |-> $stable(code));

  // R6: flag follows the sub-bits of the loaded frame
  p_subbit_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    upd |-> err == ($past(frame_word[SUB_W-1:0]) != '0));
endmodule

bind dac_serial_loader dfl_checker #(
  .CODE_W(CODE_W), .SUB_W(SUB_W), .CNT_W(CNT_W), .CLEAR(CLEAR)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .clr_n(clr_n), .code(code_o), .upd(upd_o),
  .err(subbit_err_o), .bit_cnt(bit_cnt), .frame_word(frame_word)
);

// File: tb/dac_serial_loader_tb.sv
module dac_serial_loader_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, sel_n, sclk, sdata, clr_n;
  logic [13:0] code_u, code_b;
  logic        upd_u, upd_b, err_u, err_b;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  int doubles = 0;
  logic upd_prev = 1'b0;

  always #4 clk = ~clk;

  dac_serial_loader #(.BIPOLAR(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdata(sdata),
    .clr_n(clr_n), .code_o(code_u), .upd_o(upd_u), .subbit_err_o(err_u)
  );

  dac_serial_loader #(.BIPOLAR(1'b1)) dut_bip_i (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdata(sdata),
    .clr_n(clr_n), .code_o(code_b), .upd_o(upd_b), .subbit_err_o(err_b)
  );

  always @(negedge clk) begin
    if (upd_u) pulses++;
    if (upd_u && upd_prev) doubles++;
    upd_prev <= upd_u;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel_low();  sel_n = 1'b0; wait_clk(4); endtask
  task automatic sel_high(); wait_clk(4); sel_n = 1'b1; wait_clk(10); endtask

  task automatic shift_bits(input logic [31:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdata = w[i];
      wait_clk(4);
      sclk = 1'b1;
      wait_clk(4);
      sclk = 1'b0;
    end
  endtask

  task automatic frame(input logic [31:0] w, input int n);
    sel_low();
    shift_bits(w, n);
    sel_high();
  endtask

  task automatic t_reset();
    chk(code_u == 14'h0000, "R1 unipolar reset code", code_u, 0);
    chk(code_b == 14'h2000, "R1 bipolar reset code", code_b, 14'h2000);
    chk(upd_u == 1'b0, "R1 strobe at reset", upd_u, 0);
    chk(err_u == 1'b0, "R1 flag at reset", err_u, 0);
  endtask

  task automatic t_basic();
    int p0 = pulses;
    frame({14'h2A5C, 2'b00}, 16);
    chk(code_u == 14'h2A5C, "R2 code load", code_u, 14'h2A5C);
    chk(pulses == p0 + 1, "R8 one strobe", pulses, p0 + 1);
    frame({14'h3FFF, 2'b00}, 16);
    chk(code_u == 14'h3FFF, "R2 full scale", code_u, 14'h3FFF);
    chk(code_b == 14'h3FFF, "R2 bipolar load", code_b, 14'h3FFF);
    frame({14'h0001, 2'b00}, 16);
    chk(code_u == 14'h0001, "R2 lsb only", code_u, 1);
  endtask

  task automatic t_hold_until_release();
    sel_low();
    shift_bits({14'h1234, 2'b00}, 16);
    wait_clk(8);
    chk(code_u == 14'h0001, "R3 hold before select rise", code_u, 1);
    sel_high();
    chk(code_u == 14'h1234, "R3 load after select rise", code_u, 14'h1234);
  endtask

  task automatic t_short_long();
    int p0 = pulses;
    frame({15'h7FFF}, 15);
    chk(code_u == 14'h1234, "R4 short frame discarded", code_u, 14'h1234);
    frame({17'h1FFFF}, 17);
    chk(code_u == 14'h1234, "R5 long frame discarded", code_u, 14'h1234);
    chk(pulses == p0, "R8 no strobe on discard", pulses, p0);
  endtask

  task automatic t_subbits();
    frame({14'h0ABC, 2'b01}, 16);
    chk(code_u == 14'h0ABC, "R6 code loads with bad sub-bits", code_u, 14'h0ABC);
    chk(err_u == 1'b1, "R6 flag set", err_u, 1);
    frame({14'h0000, 2'b00}, 15);
    chk(err_u == 1'b1, "R6 flag held over discard", err_u, 1);
    frame({14'h0DEF, 2'b00}, 16);
    chk(err_u == 1'b0, "R6 flag cleared", err_u, 0);
    chk(code_u == 14'h0DEF, "R6 clean load", code_u, 14'h0DEF);
  endtask

  task automatic t_clear();
    int p0 = pulses;
    #2 clr_n = 1'b0;
    #1;
    chk(code_u == 14'h0000, "R7 unipolar clear immediate", code_u, 0);
    chk(code_b == 14'h2000, "R7 bipolar clear immediate", code_b, 14'h2000);
    wait_clk(3);
    clr_n = 1'b1;
    wait_clk(3);
    chk(code_u == 14'h0000, "R7 clear code held after release", code_u, 0);
    chk(pulses == p0, "R8 no strobe on clear", pulses, p0);
  endtask

  task automatic t_clear_mid_frame();
    int p0 = pulses;
    sel_low();
    shift_bits(32'hA5, 8);
    clr_n = 1'b0;
    wait_clk(3);
    chk(code_u == 14'h0000, "R9 clear during frame", code_u, 0);
    clr_n = 1'b1;
    wait_clk(2);
    shift_bits(32'hC4, 8);
    sel_high();
    chk(code_u == 14'h2971, "R9 frame survives clear", code_u, 14'h2971);
    chk(pulses == p0 + 1, "R9 strobe after clear", pulses, p0 + 1);
  endtask

  task automatic t_idle_clocks();
    int p0 = pulses;
    for (int i = 0; i < 20; i++) begin
      sdata = i[0];
      wait_clk(4); sclk = 1'b1; wait_clk(4); sclk = 1'b0;
    end
    wait_clk(10);
    chk(code_u == 14'h2971, "R10 idle clocks ignored", code_u, 14'h2971);
    chk(pulses == p0, "R10 no strobe on idle clocks", pulses, p0);
    frame({14'h1111, 2'b00}, 16);
    chk(code_u == 14'h1111, "R10 next frame clean", code_u, 14'h1111);
  endtask

  initial begin
    rst_n = 1'b0; sel_n = 1'b1; sclk = 1'b0; sdata = 1'b0; clr_n = 1'b1;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_basic();
    t_hold_until_release();
    t_short_long();
    t_subbits();
    t_clear();
    t_clear_mid_frame();
    t_idle_clocks();
    chk(doubles == 0, "R8 strobe width one", doubles, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule